// File: doc/BRIEF.md
# ADC Result Formatting Router

This block sits on the return path of one or more analog-to-digital converters. Each returning message brings a 4-bit tag, a 2-bit kind code and a raw payload. The block turns the payload into a 16-bit word and writes it into one of eight small result queues, chosen by the tag. Software or a downstream consumer drains each queue through a first-word-fall-through read port.

The block handles three kinds of payload. Register read data is stored as it arrives. A time stamp is the value of a free-running 16-bit time base, captured when the end of input sampling is signalled. A conversion result is either taken from a separate calibrated input, or resolution-adjusted and shifted so that a 14-bit value sits right-justified in the word.

Messages that cannot be stored are dropped and flagged. A tag outside the range of queues raises a sticky error. A message aimed at a full queue raises that queue's overflow flag, which is cleared by writing a one to it.

Top module: `adc_result_router`

## Requirements
- R1: A message is accepted on a cycle with `msg_valid` and `msg_ready` both high. Its 16-bit word is written only into the queue whose index equals `msg_tag`, and every other queue is left unchanged.
- R2: Kind code 00 (register read) and kind code 11 both store `msg_payload` unchanged.
- R3: Kind code 01 (time stamp) stores the value held by the capture register. A `sample_end` pulse loads that register from the time base, and the register holds its value until the next pulse. When a capture and a time-stamp message fall in the same cycle, the message gets the previously held value.
- R4: The 16-bit time base resets to 0, advances by one on each cycle with `tb_tick` high, and wraps modulo 65536. A capture in a cycle that also ticks takes the value from before the increment.
- R5: Kind code 10 (conversion) with `msg_cal` low works in two steps. First it forms a 12-bit value A: `msg_res` 00 or 11 gives payload[11:0], 01 gives {payload[9:0],00}, and 10 gives {payload[7:0],0000}. It then stores {00, A, 00}, so payload bits above the selected width are ignored.
- R6: Kind code 10 with `msg_cal` high stores {00, `msg_cal_data`} and ignores the payload.
- R7: A message with `msg_tag` of 8 or more writes no queue and sets `tag_err`, which stays high until reset.
- R8: A message aimed at a full queue, with no pop of that queue in the same cycle, is discarded and sets that queue's `ovf_flag` bit. The bit is cleared by a one on the matching `ovf_clr` bit. If a set and a clear fall in the same cycle, the set wins.
- R9: A message aimed at a full queue that is popped in the same cycle is accepted, and no overflow is flagged.
- R10: Reset empties all queues and clears `ovf_flag` and `tag_err`. From the first cycle after reset, `msg_ready` is high.
- R11: Each queue of depth 4 returns words in arrival order. The oldest word is shown on its slice of `fifo_rdata` (queue i at bits [16i+15:16i]). A pop of an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Return message present |
| msg_ready | output | 1 | Block can take a message this cycle |
| msg_tag | input | 4 | Destination queue index |
| msg_kind | input | 2 | 00 register data, 01 time stamp, 10 conversion, 11 register data |
| msg_res | input | 2 | Converter resolution: 00 12-bit, 01 10-bit, 10 8-bit, 11 12-bit |
| msg_cal | input | 1 | Take the conversion value from the calibrated input |
| msg_payload | input | 16 | Raw payload |
| msg_cal_data | input | 14 | Calibrated conversion value |
| tb_tick | input | 1 | Time base advance strobe |
| sample_end | input | 1 | End of input sampling; captures the time base |
| fifo_pop | input | 8 | Per-queue pop |
| fifo_rdata | output | 128 | Per-queue head word, queue i at bits [16i+15:16i] |
| fifo_empty | output | 8 | Per-queue empty |
| fifo_full | output | 8 | Per-queue full |
| ovf_flag | output | 8 | Per-queue sticky overflow |
| ovf_clr | input | 8 | Per-queue write-one-to-clear for ovf_flag |
| tag_err | output | 1 | Sticky out-of-range tag error |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a push and a pop on a full queue. The bench fills queue 3 and then sends a fifth word while popping that queue. It judges the result by the absence of an overflow flag and by the exact order of the four words it reads back. The second pair is a time-stamp capture and a time-stamp message. The bench raises `sample_end` in the same cycle as a time-stamp message, expects the earlier capture in the stored word, and then sends a second message that must carry the new capture. A tick coinciding with a capture, and an overflow set coinciding with its clear, are provoked in the same way.

// File: rtl/adc_rr_pkg.sv
// Shared encodings for the ADC result formatting router.
// Assumes: message kind and resolution codes are 2 bits wide.
package adc_rr_pkg;

    typedef enum logic [1:0] {
        KIND_REGRD = 2'b00,
        KIND_STAMP = 2'b01,
        KIND_CONV  = 2'b10,
        KIND_ALT   = 2'b11
    } msg_kind_e;

    typedef enum logic [1:0] {
        RES_12  = 2'b00,
        RES_10  = 2'b01,
        RES_08  = 2'b10,
        RES_12B = 2'b11
    } res_sel_e;

endpackage

// File: rtl/adc_rr_timebase.sv
// Free-running time base with end-of-sampling capture register.
// Assumes: tick is a one-cycle strobe; the capture takes the pre-increment value.
module adc_rr_timebase #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            capture,
    output logic [TS_W-1:0] count,
    output logic [TS_W-1:0] held
);

    // Advance the counter on each tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end

    // Latch the counter when sampling ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (capture)
            held <= count;
    end

endmodule

// File: rtl/adc_rr_formatter.sv
// Combinational payload formatter: register data, time stamp or conversion.
// Assumes: DATA_W >= ADJ_W + 2 and TS_W == DATA_W.
module adc_rr_formatter
    import adc_rr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADJ_W  = 12,
    parameter int TS_W   = 16
) (
    input  logic [1:0]                kind,
    input  logic [1:0]                res,
    input  logic                      cal,
    input  logic [DATA_W-1:0]         payload,
    input  logic [ADJ_W+1:0]          cal_data,
    input  logic [TS_W-1:0]           stamp,
    output logic [DATA_W-1:0]         word
);

    localparam int PAD   = 2;
    localparam int JUS_W = ADJ_W + PAD;
    localparam int TOP_Z = DATA_W - JUS_W;

    logic [ADJ_W-1:0]  aligned;
    logic [DATA_W-1:0] conv_word;

    // Left-align the converter data into the adjusted width.
    always_comb begin
        case (res_sel_e'(res))
            RES_10:  aligned = {payload[ADJ_W-3:0], 2'b00};
            RES_08:  aligned = {payload[ADJ_W-5:0], 4'b0000};
            default: aligned = payload[ADJ_W-1:0];
        endcase
    end

    // Pick calibrated input or shifted, right-justified raw value.
    always_comb begin
        if (cal)
            conv_word = {{TOP_Z{1'b0}}, cal_data};
        else
            conv_word = {{TOP_Z{1'b0}}, aligned, {PAD{1'b0}}};
    end

    // Select the stored word by message kind.
    always_comb begin
        case (msg_kind_e'(kind))
            KIND_STAMP: word = DATA_W'(stamp);
            KIND_CONV:  word = conv_word;
            default:    word = payload;
        endcase
    end

endmodule

// File: rtl/adc_rr_fifo.sv
// Small first-word-fall-through result queue.
// Assumes: a push to a full queue is allowed only if it is popped in the same cycle;
// a refused push is reported on 'drop'. A pop of an empty queue is ignored.
module adc_rr_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign rdata   = mem[rd_ptr];

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    // Advance pointers with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (do_push && !do_pop)
            count <= count + 1'b1;
        else if (do_pop && !do_push)
            count <= count - 1'b1;
    end

endmodule

// File: rtl/adc_result_router.sv
// ADC result formatting router: formats return payloads and routes them by tag
// into per-tag result queues, with overflow and bad-tag flags.
// Assumes: NUM_FIFO <= 2**TAG_W; one message per cycle at most.
module adc_result_router
    import adc_rr_pkg::*;
#(
    parameter int TAG_W    = 4,
    parameter int NUM_FIFO = 8,
    parameter int DEPTH    = 4,
    parameter int DATA_W   = 16,
    parameter int ADJ_W    = 12,
    parameter int TS_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       msg_valid,
    output logic                       msg_ready,
    input  logic [TAG_W-1:0]           msg_tag,
    input  logic [1:0]                 msg_kind,
    input  logic [1:0]                 msg_res,
    input  logic                       msg_cal,
    input  logic [DATA_W-1:0]          msg_payload,
    input  logic [ADJ_W+1:0]           msg_cal_data,
    input  logic                       tb_tick,
    input  logic                       sample_end,
    input  logic [NUM_FIFO-1:0]        fifo_pop,
    output logic [NUM_FIFO*DATA_W-1:0] fifo_rdata,
    output logic [NUM_FIFO-1:0]        fifo_empty,
    output logic [NUM_FIFO-1:0]        fifo_full,
    output logic [NUM_FIFO-1:0]        ovf_flag,
    input  logic [NUM_FIFO-1:0]        ovf_clr,
    output logic                       tag_err
);

    logic [TS_W-1:0]     tb_cnt;
    logic [TS_W-1:0]     ts_hold;
    logic [DATA_W-1:0]   fmt_word;
    logic                accept;
    logic                tag_ok;
    logic [NUM_FIFO-1:0] push_vec;
    logic [NUM_FIFO-1:0] drop_vec;

    assign accept   = msg_valid && msg_ready;
    assign tag_ok   = (int'(msg_tag) < NUM_FIFO);
    assign push_vec = (accept && tag_ok) ? (NUM_FIFO'(1) << msg_tag) : '0;

    // Ready comes up on the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_ready <= 1'b0;
        else
            msg_ready <= 1'b1;
    end

    adc_rr_timebase #(.TS_W(TS_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tb_tick),
        .capture (sample_end),
        .count   (tb_cnt),
        .held    (ts_hold)
    );

    adc_rr_formatter #(.DATA_W(DATA_W), .ADJ_W(ADJ_W), .TS_W(TS_W)) u_fmt (
        .kind     (msg_kind),
        .res      (msg_res),
        .cal      (msg_cal),
        .payload  (msg_payload),
        .cal_data (msg_cal_data),
        .stamp    (ts_hold),
        .word     (fmt_word)
    );

    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_q
        adc_rr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_vec[i]),
            .wdata (fmt_word),
            .pop   (fifo_pop[i]),
            .rdata (fifo_rdata[i*DATA_W +: DATA_W]),
            .empty (fifo_empty[i]),
            .full  (fifo_full[i]),
            .drop  (drop_vec[i])
        );
    end

    // Sticky per-queue overflow: a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= '0;
        else
            ovf_flag <= (ovf_flag & ~ovf_clr) | drop_vec;
    end

    // Sticky out-of-range tag error.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_err <= 1'b0;
        else if (accept && !tag_ok)
            tag_err <= 1'b1;
    end

endmodule

// File: rtl/adc_rr_checker.sv
// Property checker for the ADC result formatting router, bound to the top.
module adc_rr_checker #(
    parameter int TAG_W    = 4,
    parameter int NUM_FIFO = 8,
    parameter int TS_W     = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [TAG_W-1:0]    msg_tag,
    input logic [NUM_FIFO-1:0] fifo_pop,
    input logic [NUM_FIFO-1:0] fifo_empty,
    input logic [NUM_FIFO-1:0] fifo_full,
    input logic [NUM_FIFO-1:0] ovf_flag,
    input logic [NUM_FIFO-1:0] ovf_clr,
    input logic                tag_err,
    input logic                tb_tick,
    input logic                sample_end,
    input logic [TS_W-1:0]     tb_cnt,
    input logic [TS_W-1:0]     ts_hold
);

    // R7: an out-of-range tag raises the error flag
    a_r7_bad_tag_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready && int'(msg_tag) >= NUM_FIFO) |=> tag_err);

    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |=> tag_err);

    // R8: an overflow bit not cleared stays set
    a_r8_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_flag & $past(ovf_flag & ~ovf_clr)) == $past(ovf_flag & ~ovf_clr)));

    for (genvar i = 0; i < NUM_FIFO; i++) begin : g_chk
        // R8: a push to a full, unpopped queue flags overflow
        a_r8_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && msg_ready && int'(msg_tag) == i && fifo_full[i] && !fifo_pop[i])
            |=> ovf_flag[i]);
        // R9: a full queue popped while pushed stays full
        a_r9_push_pop_full: assert property (@(posedge clk) disable iff (!rst_n)
            (msg_valid && msg_ready && int'(msg_tag) == i && fifo_full[i] && fifo_pop[i])
            |=> fifo_full[i]);
    end

    // R11: a queue is never both full and empty
    a_r11_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full & fifo_empty) == '0);

    // R4: a tick advances the time base by one
    a_r4_tick_adv: assert property (@(posedge clk) disable iff (!rst_n)
        tb_tick |=> tb_cnt == TS_W'($past(tb_cnt) + 1'b1));

    // R4: no tick, no change
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_tick |=> $stable(tb_cnt));

    // R3: capture loads the pre-tick counter value
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        sample_end |=> ts_hold == $past(tb_cnt));

    // R3: the capture register holds between captures
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_end |=> $stable(ts_hold));

    // R10: ready from the first cycle after reset
    a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> msg_ready);

endmodule

bind adc_result_router adc_rr_checker #(
    .TAG_W(TAG_W), .NUM_FIFO(NUM_FIFO), .TS_W(TS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_tag    (msg_tag),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .ovf_flag   (ovf_flag),
    .ovf_clr    (ovf_clr),
    .tag_err    (tag_err),
    .tb_tick    (tb_tick),
    .sample_end (sample_end),
    .tb_cnt     (tb_cnt),
    .ts_hold    (ts_hold)
);

// File: tb/adc_result_router_tb.sv
module adc_result_router_tb;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         msg_valid = 1'b0;
    logic         msg_ready;
    logic [3:0]   msg_tag = '0;
    logic [1:0]   msg_kind = '0;
    logic [1:0]   msg_res = '0;
    logic         msg_cal = 1'b0;
    logic [15:0]  msg_payload = '0;
    logic [13:0]  msg_cal_data = '0;
    logic         tb_tick = 1'b0;
    logic         sample_end = 1'b0;
    logic [7:0]   fifo_pop = '0;
    logic [127:0] fifo_rdata;
    logic [7:0]   fifo_empty;
    logic [7:0]   fifo_full;
    logic [7:0]   ovf_flag;
    logic [7:0]   ovf_clr = '0;
    logic         tag_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] exp_cnt  = '0;
    logic [15:0] exp_hold = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_router u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_tag(msg_tag), .msg_kind(msg_kind), .msg_res(msg_res), .msg_cal(msg_cal),
        .msg_payload(msg_payload), .msg_cal_data(msg_cal_data), .tb_tick(tb_tick),
        .sample_end(sample_end), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .ovf_flag(ovf_flag),
        .ovf_clr(ovf_clr), .tag_err(tag_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_conv(input logic [1:0] res, input logic [15:0] p);
        logic [11:0] a;
        case (res)
            2'b01:   a = {p[9:0], 2'b00};
            2'b10:   a = {p[7:0], 4'h0};
            default: a = p[11:0];
        endcase
        return {2'b00, a, 2'b00};
    endfunction

    function automatic logic [15:0] head(input int q);
        return fifo_rdata[q*16 +: 16];
    endfunction

    task automatic send(input logic [3:0] tag, input logic [1:0] kind, input logic [1:0] res,
                        input logic cal, input logic [15:0] pl, input logic [13:0] cd);
        @(negedge clk);
        msg_tag = tag; msg_kind = kind; msg_res = res; msg_cal = cal;
        msg_payload = pl; msg_cal_data = cd; msg_valid = 1'b1;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic pop_check(input int q, input logic [15:0] exp, input string req);
        check(req, {16'h0, head(q)}, {16'h0, exp});
        fifo_pop[q] = 1'b1;
        @(negedge clk);
        fifo_pop[q] = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        @(negedge clk);
        tb_tick = 1'b1;
        repeat (n) @(negedge clk);
        tb_tick = 1'b0;
        exp_cnt = exp_cnt + 16'(n);
    endtask

    task automatic capture();
        @(negedge clk);
        sample_end = 1'b1;
        @(negedge clk);
        sample_end = 1'b0;
        exp_hold = exp_cnt;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 empty", {24'h0, fifo_empty}, 32'hFF);
        check("R10 full", {24'h0, fifo_full}, 32'h0);
        check("R10 ovf", {24'h0, ovf_flag}, 32'h0);
        check("R10 tag_err", {31'h0, tag_err}, 32'h0);
        check("R10 ready", {31'h0, msg_ready}, 32'h1);
    endtask

    task automatic t_regread();
        send(4'd2, 2'b00, 2'b00, 1'b0, 16'hA5C3, 14'h0);
        send(4'd2, 2'b11, 2'b10, 1'b1, 16'h1234, 14'h3FFF);
        check("R1 only queue 2", {24'h0, fifo_empty}, 32'hFB);
        pop_check(2, 16'hA5C3, "R2 regread");
        pop_check(2, 16'h1234, "R2 kind11 / R11 order");
        check("R11 drained", {31'h0, fifo_empty[2]}, 32'h1);
    endtask

    task automatic t_conv();
        logic [1:0]  rs [5] = '{2'b00, 2'b01, 2'b01, 2'b10, 2'b11};
        logic [15:0] pl [5] = '{16'hFABC, 16'h03FF, 16'hF955, 16'hFFA5, 16'h0123};
        for (int k = 0; k < 4; k++)
            send(4'd5, 2'b10, rs[k], 1'b0, pl[k], 14'h1555);
        for (int k = 0; k < 4; k++)
            pop_check(5, exp_conv(rs[k], pl[k]), "R5 conversion format");
        send(4'd5, 2'b10, rs[4], 1'b0, pl[4], 14'h0);
        pop_check(5, exp_conv(rs[4], pl[4]), "R5 res 11 as 12-bit");
        send(4'd6, 2'b10, 2'b10, 1'b1, 16'hFFFF, 14'h3ABC);
        pop_check(6, 16'h3ABC, "R6 calibrated path");
    endtask

    task automatic t_stamp();
        do_ticks(37);
        capture();
        do_ticks(5);
        send(4'd1, 2'b01, 2'b00, 1'b0, 16'hDEAD, 14'h0);
        pop_check(1, exp_hold, "R3 stamp held");
        // capture and stamp message in the same cycle
        @(negedge clk);
        sample_end = 1'b1;
        msg_tag = 4'd1; msg_kind = 2'b01; msg_valid = 1'b1;
        @(negedge clk);
        sample_end = 1'b0; msg_valid = 1'b0;
        pop_check(1, exp_hold, "R3 same-cycle gets old capture");
        exp_hold = exp_cnt;
        send(4'd1, 2'b01, 2'b00, 1'b0, 16'h0, 14'h0);
        pop_check(1, exp_hold, "R3 new capture");
        // tick and capture in the same cycle
        @(negedge clk);
        tb_tick = 1'b1; sample_end = 1'b1;
        @(negedge clk);
        tb_tick = 1'b0; sample_end = 1'b0;
        exp_hold = exp_cnt;
        exp_cnt = exp_cnt + 16'd1;
        send(4'd1, 2'b01, 2'b00, 1'b0, 16'h0, 14'h0);
        pop_check(1, exp_hold, "R4 tick+capture pre-increment");
    endtask

    task automatic t_wrap();
        do_ticks(65530);
        capture();
        send(4'd0, 2'b01, 2'b00, 1'b0, 16'h0, 14'h0);
        pop_check(0, exp_hold, "R4 wrap modulo 65536");
    endtask

    task automatic t_badtag();
        send(4'd9, 2'b00, 2'b00, 1'b0, 16'hBEEF, 14'h0);
        check("R7 nothing written", {24'h0, fifo_empty}, 32'hFF);
        check("R7 tag_err set", {31'h0, tag_err}, 32'h1);
        repeat (3) @(negedge clk);
        check("R7 tag_err sticky", {31'h0, tag_err}, 32'h1);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 4; k++)
            send(4'd3, 2'b00, 2'b00, 1'b0, 16'h3000 + 16'(k), 14'h0);
        check("R8 full", {31'h0, fifo_full[3]}, 32'h1);
        send(4'd3, 2'b00, 2'b00, 1'b0, 16'h3999, 14'h0);
        check("R8 ovf set", {24'h0, ovf_flag}, 32'h08);
        // set and clear together: set wins
        @(negedge clk);
        msg_tag = 4'd3; msg_kind = 2'b00; msg_payload = 16'h3888; msg_valid = 1'b1;
        ovf_clr = 8'h08;
        @(negedge clk);
        msg_valid = 1'b0; ovf_clr = '0;
        check("R8 set wins over clear", {24'h0, ovf_flag}, 32'h08);
        @(negedge clk);
        ovf_clr = 8'h08;
        @(negedge clk);
        ovf_clr = '0;
        check("R8 w1c clears", {24'h0, ovf_flag}, 32'h0);
        // push with pop on a full queue
        @(negedge clk);
        msg_tag = 4'd3; msg_payload = 16'h3004; msg_valid = 1'b1; fifo_pop = 8'h08;
        @(negedge clk);
        msg_valid = 1'b0; fifo_pop = '0;
        check("R9 no overflow", {24'h0, ovf_flag}, 32'h0);
        check("R9 still full", {31'h0, fifo_full[3]}, 32'h1);
        for (int k = 1; k < 5; k++)
            pop_check(3, 16'h3000 + 16'(k), "R9/R11 order after push+pop");
        // pop on empty has no effect
        @(negedge clk);
        fifo_pop = 8'h08;
        @(negedge clk);
        fifo_pop = '0;
        send(4'd3, 2'b00, 2'b00, 1'b0, 16'h7777, 14'h0);
        pop_check(3, 16'h7777, "R11 pop on empty ignored");
        check("R11 empty again", {31'h0, fifo_empty[3]}, 32'h1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regread();
        t_conv();
        t_stamp();
        t_wrap();
        t_overflow();
        t_badtag();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule